// File: doc/BRIEF.md
# Dual-Channel Converter Output Formatter

This block sits at the digital edge of a two-channel sampling converter. On every rising clock edge it receives one offset-binary word for each of two channels and applies the chosen output coding. It then registers both results together on the same edge and presents them on two parallel buses.

Each bus has a drive-enable flag that stands in for a three-state pad. An active-high disable input releases both buses together. Two low-power controls, sleep and power-down, stop the capture of new words so that both buses keep their last value.

A valid flag tells downstream logic when the words can be trusted. When the low-power state is left, a wake counter keeps the valid flag low for a set number of cycles. This covers the time the upstream conversion path needs to fill again.

Top module: `dual_adc_out_fmt`

## Requirements
- R1: While `rst_n` is low, both data buses read 0 and `valid_o` is 0.
- R2: With `twos_sel_i` = 0 (straight offset binary), each bus shows its channel's input word unchanged, one rising edge after capture. Examples: 0x000 is most negative, 0x200 is midscale, 0x3FF is most positive.
- R3: With `twos_sel_i` = 1 (two's complement), each bus shows the input word with bit 9 inverted and bits 8..0 unchanged. So 0x200 gives 0x000, 0x000 gives 0x200, and 0x3FF gives 0x1FF.
- R4: A change of `twos_sel_i` affects only words captured after the change. A word held during a low-power state keeps its original coding.
- R5: `drive_a_o` and `drive_b_o` both equal the inverse of `out_dis_i`, with no clock delay. The disable input leaves the held data unchanged.
- R6: While `pdown_i` is 1, both buses keep the word registered on the last edge before power-down. New input words are ignored.
- R7: While `sleep_i` is 1, both buses hold their last word. `valid_o` is 0 after any edge at which `sleep_i` or `pdown_i` is 1.
- R8: After reset or a low-power state ends, `valid_o` stays 0 for the first WAKE_CYC edges at which both `sleep_i` and `pdown_i` are 0. It becomes 1 after the next such edge. The default WAKE_CYC is 4.
- R9: Channels A and B are captured on the same rising edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sample clock; capture on rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| smp_a_i | input | DATA_W | Channel A offset-binary sample |
| smp_b_i | input | DATA_W | Channel B offset-binary sample |
| twos_sel_i | input | 1 | 1 = two's complement, 0 = offset binary |
| out_dis_i | input | 1 | 1 = release both buses |
| sleep_i | input | 1 | Sleep: channels halted, hold outputs |
| pdown_i | input | 1 | Power-down: hold outputs |
| dout_a_o | output | DATA_W | Channel A registered output word |
| dout_b_o | output | DATA_W | Channel B registered output word |
| drive_a_o | output | 1 | Channel A bus is driven |
| drive_b_o | output | 1 | Channel B bus is driven |
| valid_o | output | 1 | Output words are valid |

## Verification
The assertions check three things on every cycle:
- A held word does not move while capture is stopped.
- The lower nine bits pass through untouched when a word is captured.
- A low-power cycle is never followed by a valid flag, and the wake counter stays within its bound.

Only the bench scenarios can show the rest. The bench sweeps every input code in both codings, so it covers the exact coding of the top bit. It confirms that a held word keeps its coding when the select changes, and that the disable input does not disturb stored data. It also measures the exact cycle on which `valid_o` returns after reset and after power-down.

// File: rtl/adc_fmt_pkg.sv
package adc_fmt_pkg;
  localparam int unsigned NUM_CH = 2;

  typedef enum logic {
    CODE_OFFSET = 1'b0,
    CODE_TWOS   = 1'b1
  } coding_e;
endpackage

// File: rtl/fmt_lane.sv
module fmt_lane
  import adc_fmt_pkg::*;
#(
  parameter int unsigned DATA_W = 10
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cap_en,
  input  coding_e           coding,
  input  logic [DATA_W-1:0] smp_i,
  output logic [DATA_W-1:0] word_o
);
  localparam int unsigned MSB = DATA_W - 1;

  logic [DATA_W-1:0] word_q;
  logic [DATA_W-1:0] word_d;

  always_comb begin
    word_d = word_q;
    if (cap_en) begin
      word_d      = smp_i;
      word_d[MSB] = smp_i[MSB] ^ (coding == CODE_TWOS);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) word_q <= '0;
    else        word_q <= word_d;
  end

  assign word_o = word_q;

  // R6 / R7: no capture means the word stays put
  assert_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !cap_en |=> $stable(word_q));

  // R2 / R3: coding touches only the top bit
  assert_lsb_pass_R2: assert property (@(posedge clk) disable iff (!rst_n)
    cap_en |=> word_q[MSB-1:0] == $past(smp_i[MSB-1:0]));
endmodule

// File: rtl/wake_ctrl.sv
module wake_ctrl #(
  parameter int unsigned WAKE_CYC = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic halt_i,
  output logic valid_o
);
  // One spare code keeps the width nonzero when WAKE_CYC is 0
  localparam int unsigned CW = $clog2(WAKE_CYC + 2);
  localparam logic [CW-1:0] RELOAD = CW'(WAKE_CYC);

  logic [CW-1:0] cnt_q, cnt_d;
  logic          vld_q, vld_d;

  always_comb begin
    cnt_d = cnt_q;
    vld_d = 1'b0;
    if (halt_i) begin
      cnt_d = RELOAD;
    end else if (cnt_q != '0) begin
      cnt_d = cnt_q - 1'b1;
    end else begin
      vld_d = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= RELOAD;
      vld_q <= 1'b0;
    end else begin
      cnt_q <= cnt_d;
      vld_q <= vld_d;
    end
  end

  assign valid_o = vld_q;

  assert_halt_novalid_R7: assert property (@(posedge clk) disable iff (!rst_n)
    halt_i |=> !vld_q);

  assert_cnt_bound_R8: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= RELOAD);
endmodule

// File: rtl/dual_adc_out_fmt.sv
module dual_adc_out_fmt
  import adc_fmt_pkg::*;
#(
  parameter int unsigned DATA_W   = 10,
  parameter int unsigned WAKE_CYC = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [DATA_W-1:0] smp_a_i,
  input  logic [DATA_W-1:0] smp_b_i,
  input  logic              twos_sel_i,
  input  logic              out_dis_i,
  input  logic              sleep_i,
  input  logic              pdown_i,
  output logic [DATA_W-1:0] dout_a_o,
  output logic [DATA_W-1:0] dout_b_o,
  output logic              drive_a_o,
  output logic              drive_b_o,
  output logic              valid_o
);
  logic [DATA_W-1:0] smp_arr  [NUM_CH];
  logic [DATA_W-1:0] word_arr [NUM_CH];
  logic              halt;
  logic              cap_en;

  assign halt    = sleep_i | pdown_i;
  assign cap_en  = ~halt;

  assign smp_arr[0] = smp_a_i;
  assign smp_arr[1] = smp_b_i;

  // R9: one shared capture enable for every lane
  for (genvar ch = 0; ch < NUM_CH; ch++) begin : g_lane
    fmt_lane #(.DATA_W(DATA_W)) u_lane (
      .clk    (clk),
      .rst_n  (rst_n),
      .cap_en (cap_en),
      .coding (coding_e'(twos_sel_i)),
      .smp_i  (smp_arr[ch]),
      .word_o (word_arr[ch])
    );
  end

  wake_ctrl #(.WAKE_CYC(WAKE_CYC)) u_wake (
    .clk     (clk),
    .rst_n   (rst_n),
    .halt_i  (halt),
    .valid_o (valid_o)
  );

  assign dout_a_o  = word_arr[0];
  assign dout_b_o  = word_arr[1];
  assign drive_a_o = ~out_dis_i;
  assign drive_b_o = ~out_dis_i;
endmodule

// File: tb/dual_adc_out_fmt_tb.sv
module dual_adc_out_fmt_tb;
  localparam int W    = 10;
  localparam int WAKE = 4;

  logic         clk = 1'b0;
  logic         rst_n;
  logic [W-1:0] a, b;
  logic         tsel, dis, slp, pd;
  logic [W-1:0] da, db;
  logic         dra, drb, vld;

  int n_chk  = 0;
  int n_fail = 0;
  bit done   = 0;

  always #2 clk = ~clk;

  dual_adc_out_fmt #(.DATA_W(W), .WAKE_CYC(WAKE)) u_dut (
    .clk(clk), .rst_n(rst_n), .smp_a_i(a), .smp_b_i(b),
    .twos_sel_i(tsel), .out_dis_i(dis), .sleep_i(slp), .pdown_i(pd),
    .dout_a_o(da), .dout_b_o(db), .drive_a_o(dra), .drive_b_o(drb),
    .valid_o(vld)
  );

  task automatic tick();
    @(posedge clk);
    #1;
  endtask

  task automatic chk(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  function automatic int code(input int s, input bit t);
    return t ? (s ^ 'h200) : s;
  endfunction

  task automatic wake_check(input string req);
    for (int k = 1; k <= WAKE + 1; k++) begin
      tick();
      chk(req, vld, (k == WAKE + 1) ? 1 : 0);
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog: actual 0x0 expected 0x1");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    rst_n = 0; a = 'h155; b = 'h2AA; tsel = 0; dis = 0; slp = 0; pd = 0;
    repeat (3) tick();
    chk("R1 dout_a", da, 0);
    chk("R1 dout_b", db, 0);
    chk("R1 valid", vld, 0);
    rst_n = 1;
    wake_check("R8 after reset");

    // R2 / R3 / R9: full sweep in both codings
    for (int t = 0; t < 2; t++) begin
      tsel = t[0];
      for (int s = 0; s < 1024; s++) begin
        a = W'(s); b = W'(~s);
        tick();
        chk(t ? "R3 chan A" : "R2 chan A", da, code(s, t[0]));
        chk("R9 chan B", db, code((~s) & 'h3FF, t[0]));
        chk("R8 valid steady", vld, 1);
      end
    end

    // R3 boundary codes
    tsel = 1; a = 'h200; b = 'h000; tick();
    chk("R3 midscale", da, 'h000);
    chk("R3 most negative", db, 'h200);
    a = 'h3FF; tick();
    chk("R3 most positive", da, 'h1FF);

    // R6 / R4 / R5: power-down hold
    tsel = 0; a = 'h155; b = 'h0F0; tick();
    pd = 1; a = 'h0AA; b = 'h333; tick();
    chk("R6 hold A", da, 'h155);
    chk("R6 hold B", db, 'h0F0);
    chk("R7 valid low in power-down", vld, 0);
    tsel = 1; tick(); tick();
    chk("R4 held word keeps coding", da, 'h155);
    dis = 1; #1;
    chk("R5 drive A off", dra, 0);
    chk("R5 drive B off", drb, 0);
    tick();
    dis = 0; #1;
    chk("R5 drive A on", dra, 1);
    chk("R5 drive B on", drb, 1);
    chk("R5 data kept", da, 'h155);
    pd = 0;
    wake_check("R8 after power-down");
    chk("R4 new coding applied", da, 'h2AA);

    // R7: sleep hold
    tsel = 0; a = 'h123; b = 'h321; tick();
    slp = 1; a = 'h000; b = 'h3FF; tick(); tick();
    chk("R7 sleep hold A", da, 'h123);
    chk("R7 sleep hold B", db, 'h321);
    chk("R7 valid low in sleep", vld, 0);
    slp = 0;
    wake_check("R8 after sleep");
    chk("R2 capture after sleep", da, 'h000);

    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
    $finish;
  end
endmodule